// File: doc/BRIEF.md
# Compact float immediate loader

This unit is the execute stage for two floating-point immediate instructions. The first instruction puts a 16-bit immediate into a floating-point register. It reads the immediate as the upper half of a single-precision value, so it acts as a bfloat16 value. It builds the single-precision number with a zero lower half and widens it to double precision. The second instruction refines a value that is already in the register. It narrows the double held there to single precision, overwrites the lower 16 bits of that single with a fresh immediate, and widens the result back to double. Issuing the first instruction and then the second gives any exact single-precision constant in two instructions, with no memory access.

The unit receives a 32-bit instruction word, a decoded operation select and the current register contents. It returns the value to write and a one-cycle write strobe. Both appear one clock after the instruction is presented. Status flags, the register file and pipeline control live outside this unit.

Top module: `fimm_loader`

## Requirements
- R1: The immediate is `{insn[15:6], insn[20:16], insn[0]}`, with `insn[31]` being the first bit of the word. The bits `insn[31:21]` and `insn[5:1]` have no effect on the written value.
- R2: With `op_sel`=0 (load), the written value is the double-precision equivalent of the single-precision word `{imm, 16'h0000}`.
- R3: Load immediates produce these values: 0x3F80 gives 0x3FF0_0000_0000_0000, 0x8000 gives 0x8000_0000_0000_0000, 0x7F80 gives 0x7FF0_0000_0000_0000, and 0x7FC0 gives 0x7FF8_0000_0000_0000.
- R4: Widening a normal single keeps the sign, adds 896 to the exponent and left-justifies the 23 fraction bits in the 52-bit fraction. A signed zero stays a zero of the same sign.
- R5: Widening a single-precision subnormal produces the equal normal double, whose exponent is 874 plus the position of the leading one in the fraction.
- R6: A single exponent of 0xFF widens to exponent 0x7FF, with the fraction (infinity or NaN payload) copied into the top 23 fraction bits.
- R7: With `op_sel`=1 (splice), `reg_rdata` is narrowed to single precision by truncation, without rounding. Its low 16 bits are replaced by `imm`, and the result is widened back. This is exact for every double that encodes a single value.
- R8: Splicing 0x8000 into 0x3FF0_0000_0000_0000 yields 0x3FF0_1000_0000_0000.
- R9: Narrowing a double whose exponent lies in 874..896 gives the matching single subnormal. Its fraction is `{1, top23}` shifted right by 897 minus the exponent.
- R10: `wr_en` is high in exactly the cycle after each cycle with `insn_valid` high, and low otherwise.
- R11: While `insn_valid` is low, `wr_data` keeps its previous value.
- R12: While reset is asserted, `wr_en` and `wr_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction present this cycle |
| op_sel | input | 1 | 0 = load immediate, 1 = splice low half |
| insn | input | 32 | Instruction word |
| reg_rdata | input | 64 | Current target register value (splice only) |
| wr_en | output | 1 | Register write strobe |
| wr_data | output | 64 | Value to write |

## Verification
The output register is the only state in the unit, so any error there shows at the ports one clock after the instruction that caused it. Errors of this kind are a lost or doubled strobe, or a value that is not held between instructions. A fault in the converters shows up in the value written for that same instruction. A wrong exponent offset, a wrong leading-one position or a lost NaN payload each change specific exponent or fraction bits, and the bench compares all 64 bits against its own conversion model. The splice path is also checked through register values built from subnormals, infinities and NaNs, because a narrowing fault is visible only after the value is widened again.

// File: rtl/fimm_pkg.sv
package fimm_pkg;
  localparam int INSN_W    = 32;
  localparam int IMM_W     = 16;
  localparam int F32_EXP_W = 8;
  localparam int F32_MAN_W = 23;
  localparam int F32_W     = 1 + F32_EXP_W + F32_MAN_W;
  localparam int F64_EXP_W = 11;
  localparam int F64_MAN_W = 52;
  localparam int F64_W     = 1 + F64_EXP_W + F64_MAN_W;
  localparam int F32_BIAS  = (1 << (F32_EXP_W - 1)) - 1;
  localparam int F64_BIAS  = (1 << (F64_EXP_W - 1)) - 1;
  localparam int BIAS_GAP  = F64_BIAS - F32_BIAS;
  localparam int MAN_PAD   = F64_MAN_W - F32_MAN_W;
  localparam int LEAD_W    = $clog2(F32_MAN_W);

  typedef struct packed {
    logic                 sgn;
    logic [F32_EXP_W-1:0] exp;
    logic [F32_MAN_W-1:0] man;
  } f32_t;

  typedef struct packed {
    logic                 sgn;
    logic [F64_EXP_W-1:0] exp;
    logic [F64_MAN_W-1:0] man;
  } f64_t;

  typedef enum logic {
    OP_LOAD   = 1'b0,
    OP_SPLICE = 1'b1
  } fimm_op_e;
endpackage

// File: rtl/fimm_imm_extract.sv
module fimm_imm_extract
  import fimm_pkg::*;
#(
  parameter int WORD_W = INSN_W,
  parameter int OUT_W  = IMM_W
) (
  input  logic [WORD_W-1:0] insn,
  output logic [OUT_W-1:0]  imm
);
  // Field positions counted from the most significant bit (index 0).
  localparam int HI_FIRST  = 16;
  localparam int HI_LEN    = 10;
  localparam int MID_FIRST = 11;
  localparam int MID_LEN   = 5;
  localparam int LOW_POS   = 31;

  localparam int HI_TOP  = WORD_W - 1 - HI_FIRST;
  localparam int MID_TOP = WORD_W - 1 - MID_FIRST;
  localparam int LOW_BIT = WORD_W - 1 - LOW_POS;

  logic unused_word;
  assign unused_word = ^insn;

  assign imm = {insn[HI_TOP -: HI_LEN], insn[MID_TOP -: MID_LEN], insn[LOW_BIT]};
endmodule

// File: rtl/fimm_lead_one.sv
module fimm_lead_one #(
  parameter int VEC_W = 23,
  parameter int POS_W = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0] vec,
  output logic [POS_W-1:0] pos,
  output logic             found
);
  logic [VEC_W-1:0] above_clear;
  logic [VEC_W-1:0] is_lead;

  // above_clear[i]: no set bit strictly above position i.
  genvar gi;
  generate
    for (gi = 0; gi < VEC_W; gi++) begin : g_bit
      if (gi == VEC_W - 1) begin : g_top
        assign above_clear[gi] = 1'b1;
      end else begin : g_rest
        assign above_clear[gi] = above_clear[gi+1] & ~vec[gi+1];
      end
      assign is_lead[gi] = vec[gi] & above_clear[gi];
    end
  endgenerate

  always_comb begin
    pos = '0;
    for (int i = 0; i < VEC_W; i++) begin
      if (is_lead[i]) pos = POS_W'(i);
    end
  end

  assign found = |vec;
endmodule

// File: rtl/fimm_widen.sv
module fimm_widen
  import fimm_pkg::*;
(
  input  f32_t src,
  output f64_t dst
);
  localparam int SUB_EXP_BASE = BIAS_GAP + 1 - F32_MAN_W;
  localparam logic [F32_EXP_W-1:0] E32_ONES = '1;
  localparam logic [F64_EXP_W-1:0] E64_ONES = '1;

  logic [LEAD_W-1:0]    lead_pos;
  logic                 lead_found;
  logic [LEAD_W-1:0]    norm_shift;
  logic [F32_MAN_W-1:0] norm_man;

  fimm_lead_one #(.VEC_W(F32_MAN_W), .POS_W(LEAD_W)) u_lead (
    .vec   (src.man),
    .pos   (lead_pos),
    .found (lead_found)
  );

  // Shift that moves the leading one just past the top of the fraction.
  assign norm_shift = LEAD_W'(F32_MAN_W) - lead_pos;
  assign norm_man   = src.man << norm_shift;

  always_comb begin
    dst.sgn = src.sgn;
    dst.exp = '0;
    dst.man = '0;
    if (src.exp == E32_ONES) begin
      dst.exp = E64_ONES;
      dst.man = {src.man, {MAN_PAD{1'b0}}};
    end else if (src.exp != '0) begin
      dst.exp = F64_EXP_W'(src.exp) + F64_EXP_W'(BIAS_GAP);
      dst.man = {src.man, {MAN_PAD{1'b0}}};
    end else if (lead_found) begin
      dst.exp = F64_EXP_W'(lead_pos) + F64_EXP_W'(SUB_EXP_BASE);
      dst.man = {norm_man, {MAN_PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/fimm_narrow.sv
module fimm_narrow
  import fimm_pkg::*;
(
  input  f64_t src,
  output f32_t dst
);
  localparam int NORM_FLOOR = BIAS_GAP + 1;
  localparam int NORM_CEIL  = BIAS_GAP + (1 << F32_EXP_W) - 2;
  localparam int SUB_FLOOR  = NORM_FLOOR - F32_MAN_W;
  localparam logic [F64_EXP_W-1:0] E64_ONES = '1;
  localparam logic [F32_EXP_W-1:0] E32_ONES = '1;

  logic [F32_MAN_W-1:0] top_man;
  logic [F64_EXP_W-1:0] sub_amt;
  logic [F32_MAN_W:0]   sub_sig;
  logic                 unused_low;

  assign top_man    = src.man[F64_MAN_W-1 -: F32_MAN_W];
  assign unused_low = ^src.man[MAN_PAD-1:0];
  assign sub_amt    = F64_EXP_W'(NORM_FLOOR) - src.exp;
  assign sub_sig    = {1'b1, top_man} >> sub_amt[LEAD_W-1:0];

  always_comb begin
    dst.sgn = src.sgn;
    dst.exp = '0;
    dst.man = '0;
    if (src.exp == E64_ONES) begin
      dst.exp = E32_ONES;
      dst.man = top_man;
    end else if (src.exp > F64_EXP_W'(NORM_CEIL)) begin
      dst.exp = E32_ONES;
    end else if (src.exp >= F64_EXP_W'(NORM_FLOOR)) begin
      dst.exp = F32_EXP_W'(src.exp - F64_EXP_W'(BIAS_GAP));
      dst.man = top_man;
    end else if (src.exp >= F64_EXP_W'(SUB_FLOOR)) begin
      dst.man = sub_sig[F32_MAN_W-1:0];
    end
  end
endmodule

// File: rtl/fimm_loader.sv
module fimm_loader
  import fimm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic              op_sel,
  input  logic [INSN_W-1:0] insn,
  input  logic [F64_W-1:0]  reg_rdata,
  output logic              wr_en,
  output logic [F64_W-1:0]  wr_data
);
  localparam int KEEP_W = F32_W - IMM_W;

  fimm_op_e         op;
  logic [IMM_W-1:0] imm;
  f32_t             narrowed;
  f32_t             widen_in;
  f64_t             widened;

  logic             wr_en_d, wr_en_q;
  logic [F64_W-1:0] wr_data_d, wr_data_q;

  assign op = fimm_op_e'(op_sel);

  fimm_imm_extract #(.WORD_W(INSN_W), .OUT_W(IMM_W)) u_extract (
    .insn (insn),
    .imm  (imm)
  );

  fimm_narrow u_narrow (
    .src (f64_t'(reg_rdata)),
    .dst (narrowed)
  );

  // Operand for the shared widener: fresh upper half, or spliced lower half.
  always_comb begin
    if (op == OP_SPLICE) begin
      widen_in = f32_t'((narrowed & {{KEEP_W{1'b1}}, {IMM_W{1'b0}}}) | {{KEEP_W{1'b0}}, imm});
    end else begin
      widen_in = f32_t'({imm, {KEEP_W{1'b0}}});
    end
  end

  fimm_widen u_widen (
    .src (widen_in),
    .dst (widened)
  );

  always_comb begin
    wr_en_d   = insn_valid;
    wr_data_d = wr_data_q;
    if (insn_valid) wr_data_d = widened;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
    end else begin
      wr_en_q   <= wr_en_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_data = wr_data_q;
endmodule

// File: rtl/fimm_loader_chk.sv
module fimm_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_valid,
  input logic        op_sel,
  input logic [31:0] insn,
  input logic        wr_en,
  input logic [63:0] wr_data
);
  // R10: strobe follows every accepted instruction
  a_r10_strobe_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |=> wr_en);

  // R10: no strobe without an instruction
  a_r10_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !wr_en);

  // R11: value held while idle
  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> $stable(wr_data));

  // R2: load keeps the immediate's sign and leaves the low fraction clear
  a_r2_load_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !op_sel) |=> (wr_data[63] == $past(insn[15])));

  a_r2_load_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !op_sel) |=> (wr_data[44:0] == 45'd0));

  // R7: splice result is always a widened single
  a_r7_splice_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && op_sel) |=> (wr_data[28:0] == 29'd0));

  // R6: all-ones exponent maps to all-ones exponent
  a_r6_special_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !op_sel && insn[14:7] == 8'hFF) |=> (wr_data[62:52] == 11'h7FF));

  // R4: normal exponent rebias
  a_r4_rebias: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !op_sel && insn[14:7] != 8'h00 && insn[14:7] != 8'hFF)
    |=> (wr_data[62:52] == ($past({3'b000, insn[14:7]}) + 11'd896)));
endmodule

bind fimm_loader fimm_loader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_valid (insn_valid),
  .op_sel     (op_sel),
  .insn       (insn),
  .wr_en      (wr_en),
  .wr_data    (wr_data)
);

// File: tb/fimm_loader_bench.sv
`timescale 1ns/1ps
module fimm_loader_bench;
  logic        clk;
  logic        rst_n;
  logic        insn_valid;
  logic        op_sel;
  logic [31:0] insn;
  logic [63:0] reg_rdata;
  logic        wr_en;
  logic [63:0] wr_data;

  int total = 0;
  int bad   = 0;

  fimm_loader u_fimm_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .op_sel     (op_sel),
    .insn       (insn),
    .reg_rdata  (reg_rdata),
    .wr_en      (wr_en),
    .wr_data    (wr_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference widening: subnormals normalised by repeated shifting.
  function automatic logic [63:0] ref_widen(input logic [31:0] f);
    logic [7:0]  e;
    logic [23:0] m;
    int          k;
    e = f[30:23];
    m = {1'b0, f[22:0]};
    if (e == 8'hFF) return {f[31], 11'h7FF, f[22:0], 29'd0};
    if (e != 8'h00) return {f[31], 11'(e) + 11'd896, f[22:0], 29'd0};
    if (m == 24'd0) return {f[31], 63'd0};
    k = 0;
    while (!m[23]) begin
      m = m << 1;
      k++;
    end
    return {f[31], 11'(897 - k), m[22:0], 29'd0};
  endfunction

  function automatic logic [31:0] place_imm(input logic [15:0] imm, input logic [31:0] junk);
    logic [31:0] w;
    w = junk;
    w[15:6]  = imm[15:6];
    w[20:16] = imm[5:1];
    w[0]     = imm[0];
    return w;
  endfunction

  function automatic logic [31:0] rand_f32(input int cls);
    logic [31:0] r;
    r = $urandom;
    case (cls)
      0: r[30:23] = 8'h00;
      1: r[30:23] = 8'hFF;
      2: r[30:0]  = 31'd0;
      default: if (r[30:23] == 8'h00 || r[30:23] == 8'hFF) r[30:23] = 8'h7F;
    endcase
    return r;
  endfunction

  task automatic check64(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check1(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Drive at a falling edge; the registered result is sampled one cycle later.
  task automatic issue(input logic v, input logic sel, input logic [31:0] w, input logic [63:0] rd);
    insn_valid = v;
    op_sel     = sel;
    insn       = w;
    reg_rdata  = rd;
    @(negedge clk);
  endtask

  task automatic idle_check(input logic [63:0] held);
    issue(1'b0, $urandom_range(0, 1), $urandom, {$urandom, $urandom});
    check1("R10 idle strobe", wr_en, 1'b0);
    check64("R11 hold", wr_data, held);
  endtask

  task automatic load_check(input string req, input logic [15:0] imm, input logic [63:0] exp);
    issue(1'b1, 1'b0, place_imm(imm, $urandom), {$urandom, $urandom});
    check1("R10 strobe", wr_en, 1'b1);
    check64(req, wr_data, exp);
  endtask

  task automatic splice_check(input string req, input logic [63:0] rd,
                              input logic [15:0] imm, input logic [63:0] exp);
    issue(1'b1, 1'b1, place_imm(imm, $urandom), rd);
    check1("R10 strobe", wr_en, 1'b1);
    check64(req, wr_data, exp);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] src;
    logic [15:0] imm;
    logic [63:0] last;
    void'($urandom(32'd7741));
    rst_n = 1'b0;
    insn_valid = 1'b0;
    op_sel = 1'b0;
    insn = '0;
    reg_rdata = '0;
    repeat (3) @(negedge clk);
    check1("R12 reset strobe", wr_en, 1'b0);
    check64("R12 reset data", wr_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 directed constants
    load_check("R3 one",      16'h3F80, 64'h3FF0_0000_0000_0000);
    load_check("R3 neg zero", 16'h8000, 64'h8000_0000_0000_0000);
    load_check("R3 inf",      16'h7F80, 64'h7FF0_0000_0000_0000);
    load_check("R3 qnan",     16'h7FC0, 64'h7FF8_0000_0000_0000);
    idle_check(64'h7FF8_0000_0000_0000);
    // R5 subnormal immediate: single 0x00010000
    load_check("R5 subnormal", 16'h0001, 64'h37A0_0000_0000_0000);
    // R4 positive zero
    load_check("R4 zero", 16'h0000, 64'd0);
    // R6 NaN payload
    load_check("R6 payload", 16'h7F81, 64'h7FF0_2000_0000_0000);
    // R8 chained sequence
    splice_check("R8 chain", 64'h3FF0_0000_0000_0000, 16'h8000, 64'h3FF0_1000_0000_0000);
    idle_check(64'h3FF0_1000_0000_0000);
    // R9 smallest single subnormal in double form, splice keeps it
    splice_check("R9 tiny sub", 64'h36A0_0000_0000_0000, 16'h0001, 64'h36A0_0000_0000_0000);

    // R1: same immediate, different surrounding fields
    imm = 16'hC0A5;
    load_check("R1 fields a", imm, ref_widen({imm, 16'h0}));
    issue(1'b1, 1'b0, place_imm(imm, 32'hFFFF_FFFF), 64'd0);
    check64("R1 fields b", wr_data, ref_widen({imm, 16'h0}));
    issue(1'b1, 1'b0, place_imm(imm, 32'h0000_0000), 64'd0);
    check64("R1 fields c", wr_data, ref_widen({imm, 16'h0}));

    for (int i = 0; i < 400; i++) begin
      imm = 16'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        if ($urandom_range(0, 3) == 0) imm[14:7] = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'hFF;
        load_check("R2 random load", imm, ref_widen({imm, 16'h0}));
        last = ref_widen({imm, 16'h0});
      end else begin
        src = rand_f32($urandom_range(0, 5));
        splice_check("R7 random splice", ref_widen(src), imm, ref_widen({src[31:16], imm}));
        last = ref_widen({src[31:16], imm});
      end
      if ($urandom_range(0, 4) == 0) idle_check(last);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule